// File: doc/BRIEF.md
# Carrier Local Window Decoder

This block sits between a host bus slave and the module slots of an expansion carrier. It takes one host access per cycle, aimed at one of four windows, and turns it into a slot number, an address-space code, an offset and read or write strobes for the slot side. One window is a small byte-wide configuration area. It stores the run-time endianness flags and returns fixed bytes. The other three windows reach the modules: a control window split into I/O, ID and interrupt spaces, a 16-bit memory window and an 8-bit memory window.

The control window and the 16-bit memory window each have a big-endian flag. When the flag is set, a byte access has address bit 0 inverted before decoding. A 16-bit access has its two data bytes exchanged, on the write data going out and on the read data coming back. The 8-bit memory window is never adjusted. Strobes are raised only for slots marked present. A read aimed at an empty slot, or a read the window does not accept, returns zero. Read data and its valid flag are registered and appear one cycle after the request.

Top module: `carrier_win_decode`

## Requirements
- R1: After reset `rvalid_o`, `rdata_o`, `mod_wr_o` and `mod_rd_o` are 0, and all endian flags are clear.
- R2: For `req_win_i`=1 (control window), the slot is address bits [9:8] and the space is chosen by bits [7:6]. Value 2 gives ID (`mod_space_o`=1, offset = bits [5:0]). Value 3 gives interrupt (`mod_space_o`=3'd2, offset = bits [5:0]). Any other value gives I/O (`mod_space_o`=0, offset = bits [6:0]).
- R3: For `req_win_i`=2 (16-bit memory), the slot is bits [24:23], the offset is bits [22:0] and `mod_space_o`=3.
- R4: For `req_win_i`=3 (8-bit memory), the slot is bits [23:22], the offset is bits [21:0] and `mod_space_o`=4. Only byte accesses are accepted. A 16-bit request to this window raises no strobe and reads zero.
- R5: When the window's flag is set, a byte access (`req_wide_i`=0) to the control or 16-bit memory window is decoded with address bit 0 inverted.
- R6: When the window's flag is set, a 16-bit access to the control or 16-bit memory window swaps the bytes of the write data on `mod_wdata_o` and of the returned read data on `rdata_o`.
- R7: The 8-bit memory window applies no address flip and no data swap, whatever the flags.
- R8: A write to window 0 at byte offset 0x2B, 0x2F or 0x33 loads flag (offset−0x2B)/4 from data bit 0. Flag 1 governs the control window and flag 2 the 16-bit memory window. Writes to any other offset change nothing, and window 0 never raises a strobe.
- R9: A read of window 0 at offset k (address bits [7:0]) returns {k[6:0],0} for k < 88 and 0 otherwise. At the three flag offsets, bit 0 is ORed with the flag.
- R10: A request to a slot whose `mod_present_i` bit is 0 raises no strobe, and its read returns 0.
- R11: `rvalid_o` is 1 in the cycle after every read request and 0 otherwise. `rdata_o` is 0 when `rvalid_o` is 0.
- R12: A byte read from a module window returns `mod_rdata_i[7:0]` with the upper byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host access present this cycle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_win_i | input | 2 | 0 config, 1 control, 2 16-bit memory, 3 8-bit memory |
| req_addr_i | input | 25 | Byte address within the window |
| req_wide_i | input | 1 | 1 = 16-bit access, 0 = byte |
| req_wdata_i | input | 16 | Host write data |
| mod_present_i | input | 4 | One bit per installed slot |
| mod_rdata_i | input | 16 | Read data from the selected slot, same cycle |
| mod_sel_o | output | 2 | Selected slot |
| mod_space_o | output | 3 | Space code (0 I/O, 1 ID, 2 interrupt, 3 mem16, 4 mem8) |
| mod_off_o | output | 23 | Offset within the space |
| mod_wdata_o | output | 16 | Write data after lane adjustment |
| mod_wr_o | output | 1 | Write strobe to the slot |
| mod_rd_o | output | 1 | Read strobe to the slot |
| rdata_o | output | 16 | Registered read data |
| rvalid_o | output | 1 | Registered read completion |

## Verification
In one cycle the registered result of one read leaves the block while the next request is decoded and strobed. The bench issues reads back to back to slots with different presence and endianness and compares both against its model every cycle. A flag write is also followed at once by an access to the window it governs. The bench then judges that the new endianness applies from the very next request and not to the write's own cycle.

// File: rtl/carrier_dec_pkg.sv
`timescale 1ns/1ps
package carrier_dec_pkg;
  typedef enum logic [1:0] {WIN_CFG = 2'd0, WIN_CTL = 2'd1, WIN_M16 = 2'd2, WIN_M8 = 2'd3} win_e;
  typedef enum logic [2:0] {SP_IO = 3'd0, SP_ID = 3'd1, SP_INT = 3'd2, SP_M16 = 3'd3, SP_M8 = 3'd4} space_e;
  localparam logic [7:0] BE_BASE   = 8'h2B;
  localparam int         BE_STRIDE = 4;
  localparam int         BE_N      = 3;
  localparam int         BE_CTL    = 1;
  localparam int         BE_M16    = 2;
endpackage

// File: rtl/cde_cfg_bytes.sv
`timescale 1ns/1ps
module cde_cfg_bytes
  import carrier_dec_pkg::*;
#(
  parameter int CFG_DEPTH = 88
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [7:0]      off_i,
  input  logic            bit_i,
  output logic [BE_N-1:0] be_o,
  output logic [7:0]      rbyte_o
);
  logic [BE_N-1:0] be_q;
  logic [BE_N-1:0] at_flag;

  for (genvar i = 0; i < BE_N; i++) begin : g_flag
    localparam logic [7:0] FLAG_OFF = BE_BASE + 8'(i * BE_STRIDE);
    assign at_flag[i] = (off_i == FLAG_OFF);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 be_q[i] <= 1'b0;
      else if (wr_i && at_flag[i]) be_q[i] <= bit_i;
    end
  end

  always_comb begin
    rbyte_o = (32'(off_i) < CFG_DEPTH) ? {off_i[6:0], 1'b0} : 8'h00;
    rbyte_o[0] = rbyte_o[0] | (|(at_flag & be_q));
  end

  assign be_o = be_q;
endmodule

// File: rtl/cde_slicer.sv
`timescale 1ns/1ps
module cde_slicer
  import carrier_dec_pkg::*;
#(
  parameter int ADDR_W = 25,
  parameter int MOD_W  = 2,
  parameter int OFF_W  = 23
) (
  input  win_e              win_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [MOD_W-1:0]  mod_o,
  output space_e            space_o,
  output logic [OFF_W-1:0]  off_o
);
  localparam int CTL_MOD_LSB = 8;
  localparam int CTL_SP_LSB  = 6;
  localparam int M16_OFF_W   = OFF_W;
  localparam int M8_OFF_W    = OFF_W - 1;

  always_comb begin
    mod_o   = '0;
    space_o = SP_IO;
    off_o   = '0;
    unique case (win_i)
      WIN_CTL: begin
        mod_o = addr_i[CTL_MOD_LSB +: MOD_W];
        unique case (addr_i[CTL_SP_LSB +: 2])
          2'd2: begin space_o = SP_ID;  off_o = OFF_W'(addr_i[5:0]); end
          2'd3: begin space_o = SP_INT; off_o = OFF_W'(addr_i[5:0]); end
          default: begin space_o = SP_IO; off_o = OFF_W'(addr_i[6:0]); end
        endcase
      end
      WIN_M16: begin
        mod_o   = addr_i[M16_OFF_W +: MOD_W];
        space_o = SP_M16;
        off_o   = addr_i[M16_OFF_W-1:0];
      end
      WIN_M8: begin
        mod_o   = addr_i[M8_OFF_W +: MOD_W];
        space_o = SP_M8;
        off_o   = OFF_W'(addr_i[M8_OFF_W-1:0]);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cde_swap.sv
`timescale 1ns/1ps
module cde_swap #(
  parameter int LANE_W = 8
) (
  input  logic              en_i,
  input  logic [2*LANE_W-1:0] d_i,
  output logic [2*LANE_W-1:0] d_o
);
  assign d_o = en_i ? {d_i[LANE_W-1:0], d_i[2*LANE_W-1:LANE_W]} : d_i;
endmodule

// File: rtl/carrier_win_decode.sv
`timescale 1ns/1ps
module carrier_win_decode
  import carrier_dec_pkg::*;
#(
  parameter int ADDR_W    = 25,
  parameter int MOD_N     = 4,
  parameter int DATA_W    = 16,
  parameter int CFG_DEPTH = 88,
  localparam int MOD_W    = $clog2(MOD_N),
  localparam int OFF_W    = ADDR_W - MOD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [1:0]        req_win_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_wide_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [MOD_N-1:0]  mod_present_i,
  input  logic [DATA_W-1:0] mod_rdata_i,
  output logic [MOD_W-1:0]  mod_sel_o,
  output logic [2:0]        mod_space_o,
  output logic [OFF_W-1:0]  mod_off_o,
  output logic [DATA_W-1:0] mod_wdata_o,
  output logic              mod_wr_o,
  output logic              mod_rd_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  localparam int LANE_W = DATA_W / 2;

  win_e              win;
  logic [BE_N-1:0]   be;
  logic [7:0]        cfg_byte;
  logic              be_win, flip, swap_en, legal, hit, is_rd;
  logic [ADDR_W-1:0] addr_adj;
  space_e            space;
  logic [DATA_W-1:0] rd_swapped, rd_next;

  assign win = win_e'(req_win_i);

  cde_cfg_bytes #(.CFG_DEPTH(CFG_DEPTH)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (req_valid_i && req_we_i && win == WIN_CFG),
    .off_i   (req_addr_i[7:0]),
    .bit_i   (req_wdata_i[0]),
    .be_o    (be),
    .rbyte_o (cfg_byte)
  );

  always_comb begin
    unique case (win)
      WIN_CTL: be_win = be[BE_CTL];
      WIN_M16: be_win = be[BE_M16];
      default: be_win = 1'b0;
    endcase
  end

  assign flip     = be_win && !req_wide_i;
  assign swap_en  = be_win && req_wide_i;
  assign addr_adj = req_addr_i ^ ADDR_W'(flip);

  cde_slicer #(.ADDR_W(ADDR_W), .MOD_W(MOD_W), .OFF_W(OFF_W)) u_slice (
    .win_i   (win),
    .addr_i  (addr_adj),
    .mod_o   (mod_sel_o),
    .space_o (space),
    .off_o   (mod_off_o)
  );

  cde_swap #(.LANE_W(LANE_W)) u_wswap (.en_i(swap_en), .d_i(req_wdata_i), .d_o(mod_wdata_o));
  cde_swap #(.LANE_W(LANE_W)) u_rswap (.en_i(swap_en), .d_i(mod_rdata_i), .d_o(rd_swapped));

  assign mod_space_o = space;
  assign legal    = (win != WIN_CFG) && !(win == WIN_M8 && req_wide_i);
  assign hit      = req_valid_i && legal && mod_present_i[mod_sel_o];
  assign mod_wr_o = hit && req_we_i;
  assign mod_rd_o = hit && !req_we_i;
  assign is_rd    = req_valid_i && !req_we_i;

  always_comb begin
    if (win == WIN_CFG)  rd_next = DATA_W'(cfg_byte);
    else if (!hit)       rd_next = '0;
    else if (req_wide_i) rd_next = rd_swapped;
    else                 rd_next = DATA_W'(mod_rdata_i[LANE_W-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= is_rd;
      rdata_o  <= is_rd ? rd_next : '0;
    end
  end
endmodule

// File: rtl/cde_checks.sv
`timescale 1ns/1ps
module cde_checks #(
  parameter int ADDR_W = 25,
  parameter int MOD_N  = 4,
  parameter int DATA_W = 16,
  parameter int MOD_W  = 2,
  parameter int OFF_W  = 23
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_we_i,
  input logic [1:0]        req_win_i,
  input logic              req_wide_i,
  input logic [MOD_N-1:0]  mod_present_i,
  input logic [MOD_W-1:0]  mod_sel_o,
  input logic [2:0]        mod_space_o,
  input logic [OFF_W-1:0]  mod_off_o,
  input logic              mod_wr_o,
  input logic              mod_rd_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rvalid_o
);
  assert_strobe_needs_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_wr_o || mod_rd_o) |-> req_valid_i);

  assert_m8_narrow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mod_wr_o || mod_rd_o) && mod_space_o == 3'd4) |-> (!req_wide_i && !mod_off_o[OFF_W-1]));

  assert_cfg_no_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_win_i == 2'd0) |-> (!mod_wr_o && !mod_rd_o));

  assert_present_only_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_wr_o || mod_rd_o) |-> mod_present_i[mod_sel_o]);

  assert_dropped_read_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_we_i && req_win_i != 2'd0 && !mod_rd_o) |=> (rdata_o == '0));

  assert_rvalid_follows_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_we_i) |=> rvalid_o);

  assert_rvalid_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && !req_we_i) |=> (!rvalid_o && rdata_o == '0));

  assert_byte_upper_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_we_i && !req_wide_i && req_win_i != 2'd0) |=> (rdata_o[DATA_W-1:DATA_W/2] == '0));
endmodule

bind carrier_win_decode cde_checks #(
  .ADDR_W(ADDR_W), .MOD_N(MOD_N), .DATA_W(DATA_W), .MOD_W(MOD_W), .OFF_W(OFF_W)
) u_cde_checks (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_we_i(req_we_i),
  .req_win_i(req_win_i), .req_wide_i(req_wide_i), .mod_present_i(mod_present_i),
  .mod_sel_o(mod_sel_o), .mod_space_o(mod_space_o), .mod_off_o(mod_off_o),
  .mod_wr_o(mod_wr_o), .mod_rd_o(mod_rd_o), .rdata_o(rdata_o), .rvalid_o(rvalid_o)
);

// File: tb/test_carrier_win_decode.sv
`timescale 1ns/1ps
module test_carrier_win_decode;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_we_i = 1'b0;
  logic [1:0]  req_win_i = 2'd0;
  logic [24:0] req_addr_i = '0;
  logic        req_wide_i = 1'b0;
  logic [15:0] req_wdata_i = '0;
  logic [3:0]  mod_present_i = 4'hF;
  logic [15:0] mod_rdata_i = '0;
  logic [1:0]  mod_sel_o;
  logic [2:0]  mod_space_o;
  logic [22:0] mod_off_o;
  logic [15:0] mod_wdata_o;
  logic        mod_wr_o, mod_rd_o;
  logic [15:0] rdata_o;
  logic        rvalid_o;

  carrier_win_decode i_carrier_win_decode (.*);

  always #2 clk_i = ~clk_i;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  bit be_m[3] = '{0, 0, 0};
  int pend_valid = 0;
  int pend_data = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int swp(int d);
    return ((d & 255) << 8) | ((d >> 8) & 255);
  endfunction

  function automatic int cfg_val(int k);
    int v;
    v = (k < 88) ? ((k << 1) & 255) : 0;
    if (k == 'h2B || k == 'h2F || k == 'h33) v = v | int'(be_m[(k - 'h2B) / 4]);
    return v;
  endfunction

  // one bus cycle: check registered result, drive request, check decode, update model
  task automatic cyc(string req, bit v, bit we, int win, int addr, bit wide, int wd, int rdm);
    int a, sel, sp, off, code, wexp;
    bit bw, legal, hit;
    @(negedge clk_i);
    chk(req, "rvalid_o", int'(rvalid_o), pend_valid);
    chk(req, "rdata_o", int'(rdata_o), pend_data);
    req_valid_i = v; req_we_i = we; req_win_i = 2'(win); req_addr_i = 25'(addr);
    req_wide_i = wide; req_wdata_i = 16'(wd); mod_rdata_i = 16'(rdm);
    #0.5;
    bw = (win == 1) ? be_m[1] : (win == 2) ? be_m[2] : 1'b0;
    a = (bw && !wide) ? (addr ^ 1) : addr;
    sel = 0; sp = 0; off = 0;
    if (win == 1) begin
      sel = (a >> 8) & 3; code = (a >> 6) & 3;
      sp = (code == 2) ? 1 : (code == 3) ? 2 : 0;
      off = (code >= 2) ? (a & 'h3F) : (a & 'h7F);
    end else if (win == 2) begin
      sel = (a >> 23) & 3; sp = 3; off = a & 'h7FFFFF;
    end else if (win == 3) begin
      sel = (a >> 22) & 3; sp = 4; off = a & 'h3FFFFF;
    end
    legal = (win != 0) && !(win == 3 && wide);
    hit = v && legal && mod_present_i[sel];
    wexp = (bw && wide) ? swp(wd) : wd;
    chk(req, "mod_wr_o", int'(mod_wr_o), int'(hit && we));
    chk(req, "mod_rd_o", int'(mod_rd_o), int'(hit && !we));
    if (hit) begin
      chk(req, "mod_sel_o", int'(mod_sel_o), sel);
      chk(req, "mod_space_o", int'(mod_space_o), sp);
      chk(req, "mod_off_o", int'(mod_off_o), off);
      if (we) chk(req, "mod_wdata_o", int'(mod_wdata_o), wexp);
    end
    pend_valid = int'(v && !we);
    if (!(v && !we))  pend_data = 0;
    else if (win == 0) pend_data = cfg_val(addr & 255);
    else if (!hit)     pend_data = 0;
    else if (wide)     pend_data = bw ? swp(rdm) : rdm;
    else               pend_data = rdm & 255;
    if (v && we && win == 0) begin
      int k = addr & 255;
      if (k == 'h2B || k == 'h2F || k == 'h33) be_m[(k - 'h2B) / 4] = wd[0];
    end
  endtask

  task automatic idle(string req);
    cyc(req, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #9;
    chk("R1", "rvalid_o in reset", int'(rvalid_o), 0);
    chk("R1", "rdata_o in reset", int'(rdata_o), 0);
    rst_ni = 1'b1;
    idle("R1");
    cyc("R1", 1, 0, 0, 'h2F, 0, 0, 0);       // flag clear -> 0x5E
    cyc("R9", 1, 0, 0, 'h00, 0, 0, 0);
    cyc("R9", 1, 0, 0, 'h10, 0, 0, 0);
    cyc("R9", 1, 0, 0, 'h57, 0, 0, 0);
    cyc("R9", 1, 0, 0, 'h58, 0, 0, 0);
    cyc("R9", 1, 0, 0, 'hC0, 0, 0, 0);
    // control window, all space codes, back-to-back
    cyc("R2", 1, 0, 1, 'h035, 1, 0, 'h1357);
    cyc("R2", 1, 0, 1, 'h17F, 1, 0, 'h2468);
    cyc("R2", 1, 0, 1, 'h2A5, 1, 0, 'hBEEF);
    cyc("R2", 1, 1, 1, 'h3E1, 1, 'h5AA5, 0);
    cyc("R12", 1, 0, 1, 'h0C2, 0, 0, 'hABCD);
    cyc("R3", 1, 0, 2, 'h1ABCDEF, 1, 0, 'h7E81);
    cyc("R3", 1, 1, 2, 'h0812345, 1, 'h1234, 0);
    cyc("R12", 1, 0, 2, 'h0000101, 0, 0, 'hFF3C);
    cyc("R4", 1, 0, 3, 'h0C12345, 0, 0, 'hA55A);
    cyc("R4", 1, 1, 3, 'h0412346, 0, 'h0077, 0);
    cyc("R4", 1, 0, 3, 'h0812345, 1, 0, 'hFFFF);
    cyc("R4", 1, 1, 3, 'h0812345, 1, 'h1111, 0);
    // empty slots
    mod_present_i = 4'b1010;
    cyc("R10", 1, 0, 1, 'h035, 1, 0, 'hCAFE);
    cyc("R10", 1, 1, 2, 'h0000010, 1, 'h4321, 0);
    cyc("R10", 1, 0, 2, 'h0800010, 1, 0, 'h4321);
    cyc("R10", 1, 0, 3, 'h0C00003, 0, 0, 'h0099);
    mod_present_i = 4'hF;
    // flag writes and read-back
    cyc("R8", 1, 1, 0, 'h2F, 0, 'h0001, 0);
    cyc("R5", 1, 0, 1, 'h100, 0, 0, 'h00AB);   // new flag applies at once
    cyc("R8", 1, 1, 0, 'h33, 0, 'h00FF, 0);
    cyc("R8", 1, 1, 0, 'h2B, 0, 'h0001, 0);
    cyc("R8", 1, 1, 0, 'h2C, 0, 'h0001, 0);
    cyc("R8", 1, 0, 0, 'h2B, 0, 0, 0);
    cyc("R8", 1, 0, 0, 'h2C, 0, 0, 0);
    cyc("R8", 1, 0, 0, 'h2F, 0, 0, 0);
    cyc("R8", 1, 0, 0, 'h33, 0, 0, 0);
    cyc("R8", 1, 1, 0, 'h30, 0, 'h0000, 0);
    cyc("R8", 1, 0, 0, 'h33, 0, 0, 0);
    // big-endian effects
    cyc("R5", 1, 1, 1, 'h2C0, 0, 'h0042, 0);
    cyc("R5", 1, 0, 2, 'h0800000, 0, 0, 'h12C4);
    cyc("R6", 1, 1, 1, 'h102, 1, 'h1234, 0);
    cyc("R6", 1, 0, 1, 'h0C4, 1, 0, 'hABCD);
    cyc("R6", 1, 1, 2, 'h1000002, 1, 'hBEEF, 0);
    cyc("R6", 1, 0, 2, 'h1800006, 1, 0, 'h0102);
    cyc("R7", 1, 0, 3, 'h0400001, 0, 0, 'h3456);
    cyc("R7", 1, 1, 3, 'h0000002, 0, 'h0033, 0);
    cyc("R12", 1, 0, 1, 'h0C1, 0, 0, 'h9876);
    // clear control flag, access right behind
    cyc("R8", 1, 1, 0, 'h2F, 0, 'h0000, 0);
    cyc("R5", 1, 0, 1, 'h101, 0, 0, 'h00EE);
    cyc("R11", 0, 1, 1, 'h101, 0, 0, 0);
    idle("R11");
    idle("R11");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule